// File: doc/BRIEF.md
# Write-Masked Control Register Pair

This block holds a 64-bit translation-control register next to a 64-bit lock register. Each implemented lock bit sits at the lowest bit position of one control field. While that lock bit is 1, the whole field keeps its old value on every control write, and the unlocked fields take the written data. Control writes reach the block through either of two encodings, a primary one and an alias. Both go through the same lock.

The lock register has two encodings of its own, and it locks itself against the lower privilege level. A lock write from the lower level is refused while any lock bit is set. A lock write from a higher level is always taken. A refused write changes nothing and raises a one-cycle reject pulse. Both stored values are always visible on output ports. A small decoder sorts every request into one of three access classes: ACC_NONE, ACC_CTRL or ACC_MASK. The classes are handled with a unique case, and the block keeps no state beyond its two registers and the reject flag.

Top module: `wm_ctrl_pair`

## Requirements
- R1: After reset, `ctrl_q` and `mask_q` are zero and `wr_reject` is low.
- R2: A control write with `mask_q` zero stores `wr_data` in `ctrl_q` one cycle later. Control bits 6, 35, 62 and 63 are reserved and always read 0.
- R3: A lock bit of 1 protects every bit of its field, and unprotected bits take `wr_data`. The new value is (old AND protect) OR (data AND NOT protect). For example, lock bit 0 guards bits 5:0, lock bit 32 guards bits 34:32, and lock bit 7 guards bit 7.
- R4: A control write through the alias encoding (`wr_enc` = 16'hC13E) is locked exactly like one through the primary encoding (16'hC102). `wr_enc` is packed as {op0[1:0], op1[2:0], CRn[3:0], CRm[3:0], op2[2:0]}.
- R5: Only these lock bits are implemented: 0, 7, 8, 10, 12, 14, 16, 22, 23, 24, 26, 28, 30, 32 and 36 to 61, which is 64'h3FFF_FFF1_55C1_5581. Every other lock bit ignores written data and reads 0.
- R6: A lock write with `wr_low` = 1 while `mask_q` is nonzero leaves all state unchanged. `wr_reject` is then high for exactly the following cycle.
- R7: A lock write with `wr_low` = 1 while `mask_q` is zero is taken.
- R8: A lock write with `wr_low` = 0 is taken whatever the current lock value, and raises no reject.
- R9: The lock alias encoding 16'hE93A (op1 = 5) behaves exactly like the primary lock encoding 16'hC13A (op0 = 3, op1 = 0, CRn = 2, CRm = 7, op2 = 2).
- R10: A request with `wr_valid` low, or with any other encoding, changes no state and raises no reject.
- R11: Control writes are never rejected, at either privilege level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request this cycle |
| wr_enc | input | 16 | System register encoding {op0,op1,CRn,CRm,op2} |
| wr_low | input | 1 | Request comes from the lower privilege level |
| wr_data | input | 64 | Write data |
| ctrl_q | output | 64 | Stored control value |
| mask_q | output | 64 | Stored lock value |
| wr_reject | output | 1 | One-cycle pulse after a refused write |

## Verification
A wrong lock bit can stay hidden until the next control write. At that write it shows on `ctrl_q` one cycle later as a field that moved when it should have held, or held when it should have moved. A self-lock decision that is wrong shows one cycle after the lock write as a changed `mask_q` together with a reject pulse, or as a missing pulse. The bench keeps a behavioural model of both registers, with its own field table. It compares all three outputs on every clock, so any divergence is reported in the cycle after the write that caused it.

// File: rtl/wm_pkg.sv
package wm_pkg;

    localparam int DW = 64;
    localparam int EW = 16;

    // Lock bits that exist: one at the lowest bit of each control field.
    localparam logic [DW-1:0] MASK_IMPL = 64'h3FFF_FFF1_55C1_5581;
    // Control bits that exist: all but 6, 35, 62, 63.
    localparam logic [DW-1:0] CTRL_IMPL = 64'h3FFF_FFF7_FFFF_FFBF;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_CTRL = 2'd1,
        ACC_MASK = 2'd2
    } acc_kind_e;

    // Index of the lock bit that owns control bit i.
    function automatic int owner_of(input int i);
        for (int j = i; j >= 0; j--) begin
            if (MASK_IMPL[j]) return j;
        end
        return 0;
    endfunction

endpackage

// File: rtl/wm_decode.sv
module wm_decode
    import wm_pkg::*;
#(
    parameter logic [EW-1:0] ENC_CTRL       = 16'hC102,
    parameter logic [EW-1:0] ENC_CTRL_ALIAS = 16'hC13E,
    parameter logic [EW-1:0] ENC_MASK       = 16'hC13A,
    parameter logic [EW-1:0] ENC_MASK_ALIAS = 16'hE93A
) (
    input  logic          valid,
    input  logic [EW-1:0] enc,
    output acc_kind_e     kind
);

    always_comb begin
        kind = ACC_NONE;
        if (valid) begin
            unique case (enc)
                ENC_CTRL, ENC_CTRL_ALIAS: kind = ACC_CTRL;
                ENC_MASK, ENC_MASK_ALIAS: kind = ACC_MASK;
                default:                  kind = ACC_NONE;
            endcase
        end
    end

endmodule

// File: rtl/wm_mask_reg.sv
module wm_mask_reg
    import wm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          low,
    input  logic [DW-1:0] data,
    output logic [DW-1:0] mask_q,
    output logic [DW-1:0] protect,
    output logic          reject_q
);

    logic locked;
    logic refuse;

    assign locked = |mask_q;
    assign refuse = wr && low && locked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= '0;
            reject_q <= 1'b0;
        end else begin
            reject_q <= refuse;
            if (wr && !refuse) begin
                mask_q <= data & MASK_IMPL;
            end
        end
    end

    // Spread each lock bit over its whole field.
    for (genvar i = 0; i < DW; i++) begin : g_spread
        if (CTRL_IMPL[i]) begin : g_used
            assign protect[i] = mask_q[owner_of(i)];
        end else begin : g_rsvd
            assign protect[i] = 1'b0;
        end
    end

    AST_LOW_LOCK_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && low && mask_q != '0) |=> (reject_q && $stable(mask_q))); // R6

    AST_HIGH_NEVER_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !low) |=> !reject_q); // R8

    AST_LOW_OPEN_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && low && mask_q == '0) |=> !reject_q); // R7

endmodule

// File: rtl/wm_ctrl_reg.sv
module wm_ctrl_reg
    import wm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] data,
    input  logic [DW-1:0] protect,
    output logic [DW-1:0] ctrl_q
);

    logic [DW-1:0] nxt;

    always_comb begin
        nxt = (ctrl_q & protect) | (data & ~protect & CTRL_IMPL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr) begin
            ctrl_q <= nxt;
        end
    end

    AST_LOCKED_FIELD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (((ctrl_q ^ $past(ctrl_q)) & $past(protect)) == '0)); // R3

    AST_OPEN_FIELD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (((ctrl_q ^ $past(data)) & ~$past(protect) & CTRL_IMPL) == '0)); // R2

endmodule

// File: rtl/wm_ctrl_pair.sv
module wm_ctrl_pair
    import wm_pkg::*;
#(
    parameter logic [EW-1:0] ENC_CTRL       = 16'hC102,
    parameter logic [EW-1:0] ENC_CTRL_ALIAS = 16'hC13E,
    parameter logic [EW-1:0] ENC_MASK       = 16'hC13A,
    parameter logic [EW-1:0] ENC_MASK_ALIAS = 16'hE93A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [EW-1:0] wr_enc,
    input  logic          wr_low,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] mask_q,
    output logic          wr_reject
);

    acc_kind_e     kind;
    logic [DW-1:0] protect;

    wm_decode #(
        .ENC_CTRL      (ENC_CTRL),
        .ENC_CTRL_ALIAS(ENC_CTRL_ALIAS),
        .ENC_MASK      (ENC_MASK),
        .ENC_MASK_ALIAS(ENC_MASK_ALIAS)
    ) u_decode (
        .valid(wr_valid),
        .enc  (wr_enc),
        .kind (kind)
    );

    wm_mask_reg u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (kind == ACC_MASK),
        .low     (wr_low),
        .data    (wr_data),
        .mask_q  (mask_q),
        .protect (protect),
        .reject_q(wr_reject)
    );

    wm_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (kind == ACC_CTRL),
        .data   (wr_data),
        .protect(protect),
        .ctrl_q (ctrl_q)
    );

    AST_IDLE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> ($stable(ctrl_q) && $stable(mask_q) && !wr_reject)); // R10

    AST_REJECT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |-> $past(wr_valid && wr_low)); // R6

    AST_CTRL_NOT_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && (wr_enc == ENC_CTRL || wr_enc == ENC_CTRL_ALIAS)) |=> !wr_reject); // R11

endmodule

// File: tb/test_wm_ctrl_pair.sv
module test_wm_ctrl_pair;

    localparam int CLK_P = 10;
    localparam logic [15:0] E_CTRL  = 16'hC102;
    localparam logic [15:0] E_CTRLA = 16'hC13E;
    localparam logic [15:0] E_MASK  = 16'hC13A;
    localparam logic [15:0] E_MASKA = 16'hE93A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_enc = '0;
    logic        wr_low = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] ctrl_q, mask_q;
    logic        wr_reject;

    wm_ctrl_pair i_wm_ctrl_pair (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_enc(wr_enc),
        .wr_low(wr_low), .wr_data(wr_data), .ctrl_q(ctrl_q),
        .mask_q(mask_q), .wr_reject(wr_reject)
    );

    always #(CLK_P/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";

    int f_lsb[$];
    int f_w[$];

    logic [63:0] m_ctrl = '0;
    logic [63:0] m_mask = '0;
    logic        m_rej = 1'b0;

    function automatic logic [63:0] spread(input logic [63:0] m);
        logic [63:0] p = '0;
        foreach (f_lsb[k])
            if (m[f_lsb[k]])
                for (int b = 0; b < f_w[k]; b++) p[f_lsb[k]+b] = 1'b1;
        return p;
    endfunction

    function automatic logic [63:0] ctrl_bits();
        return spread({64{1'b1}});
    endfunction

    function automatic logic [63:0] mask_bits();
        logic [63:0] r = '0;
        foreach (f_lsb[k]) r[f_lsb[k]] = 1'b1;
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        f_lsb.push_back(0);  f_w.push_back(6);
        f_lsb.push_back(7);  f_w.push_back(1);
        for (int l = 8; l <= 14; l += 2) begin f_lsb.push_back(l); f_w.push_back(2); end
        f_lsb.push_back(16); f_w.push_back(6);
        f_lsb.push_back(22); f_w.push_back(1);
        f_lsb.push_back(23); f_w.push_back(1);
        for (int l = 24; l <= 30; l += 2) begin f_lsb.push_back(l); f_w.push_back(2); end
        f_lsb.push_back(32); f_w.push_back(3);
        for (int l = 36; l <= 61; l++) begin f_lsb.push_back(l); f_w.push_back(1); end
    end

    // Reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0; m_mask = '0; m_rej = 1'b0;
        end else begin
            m_rej = 1'b0;
            if (wr_valid && (wr_enc == E_CTRL || wr_enc == E_CTRLA)) begin
                logic [63:0] p;
                p = spread(m_mask);
                m_ctrl = (m_ctrl & p) | (wr_data & ~p & ctrl_bits());
            end else if (wr_valid && (wr_enc == E_MASK || wr_enc == E_MASKA)) begin
                if (wr_low && m_mask != '0) m_rej = 1'b1;
                else m_mask = wr_data & mask_bits();
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check({cur_tag, " ctrl"}, ctrl_q, m_ctrl);
            check({cur_tag, " mask"}, mask_q, m_mask);
            check({cur_tag, " reject"}, {63'd0, wr_reject}, {63'd0, m_rej});
        end
    end

    task automatic do_write(input string tag, input logic [15:0] enc,
                            input logic low, input logic [63:0] d, input logic v = 1'b1);
        @(negedge clk);
        cur_tag = tag;
        wr_valid = v; wr_enc = enc; wr_low = low; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    initial begin
        #(CLK_P*100000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ctrl", ctrl_q, 64'd0);
        check("R1 mask", mask_q, 64'd0);
        check("R1 reject", {63'd0, wr_reject}, 64'd0);

        do_write("R2", E_CTRL, 1'b0, {64{1'b1}});
        check("R2 direct", ctrl_q, 64'h3FFF_FFF7_FFFF_FFBF);

        do_write("R8", E_MASK, 1'b0, 64'h0000_0001_0000_0081);
        check("R8 mask", mask_q, 64'h0000_0001_0000_0081);
        check("R8 reject", {63'd0, wr_reject}, 64'd0);

        do_write("R3", E_CTRL, 1'b0, 64'd0);
        check("R3 direct", ctrl_q, 64'h0000_0007_0000_00BF);

        do_write("R4", E_CTRLA, 1'b1, 64'h5555_5555_5555_5555);
        check("R4 direct", ctrl_q, 64'h1555_5557_5555_55BF);
        check("R11 reject", {63'd0, wr_reject}, 64'd0);

        do_write("R6", E_MASK, 1'b1, 64'd0);
        check("R6 reject", {63'd0, wr_reject}, 64'd1);
        check("R6 mask", mask_q, 64'h0000_0001_0000_0081);
        @(negedge clk);
        check("R6 pulse end", {63'd0, wr_reject}, 64'd0);

        do_write("R9", E_MASKA, 1'b1, 64'd0);
        check("R9 reject", {63'd0, wr_reject}, 64'd1);

        do_write("R5", E_MASK, 1'b0, {64{1'b1}});
        check("R5 direct", mask_q, 64'h3FFF_FFF1_55C1_5581);

        do_write("R9", E_MASKA, 1'b0, 64'd0);
        check("R9 high alias", mask_q, 64'd0);

        do_write("R7", E_MASK, 1'b1, 64'h0000_0000_0001_0000);
        check("R7 direct", mask_q, 64'h0000_0000_0001_0000);
        check("R7 reject", {63'd0, wr_reject}, 64'd0);

        do_write("R10", E_CTRL, 1'b0, 64'd0, 1'b0);
        check("R10 idle", ctrl_q, 64'h1555_5557_5555_55BF);
        do_write("R10", 16'hC13B, 1'b1, 64'd0);
        check("R10 other enc", mask_q, 64'h0000_0000_0001_0000);
        check("R10 reject", {63'd0, wr_reject}, 64'd0);

        for (int n = 0; n < 400; n++) begin
            logic [15:0] e;
            case ($urandom_range(0, 4))
                0: e = E_CTRL;  1: e = E_CTRLA; 2: e = E_MASK;
                3: e = E_MASKA; default: e = 16'h1234;
            endcase
            do_write("R3", e, 1'($urandom_range(0, 1)),
                     {$urandom(), $urandom()}, 1'($urandom_range(0, 3) != 0));
        end

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule